// File: doc/BRIEF.md
# BCD Calendar Clock with Self-Describing Hour Format

This block keeps the time of day and the calendar date in packed BCD registers and advances them by one second each time an internal prescaler counts out one second of the system clock. The registers hold seconds, minutes, hours, weekday, day of month, month and a two-digit year covering 2000 to 2099. A control register holds a halt bit that freezes all timekeeping.

The hour byte describes its own format. With bit 6 clear it counts 00 to 23. With bit 6 set it counts 1 to 12 in BCD, and bit 5 marks the afternoon. Software picks the format simply by writing the hour byte. Any register can be written through a single-cycle write port and read back through a combinational read port. A one-cycle pulse marks each one-second advance so that alarm compare logic can sample the new time.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year and 7 control. A write stores the byte as given, and `rd_data` returns the register that `rd_addr` selects.
- R2: After reset the registers read 00, 00, 00, 01, 01, 01, 00, 00 for addresses 0 to 7, and `sec_pulse` is low.
- R3: Seconds and minutes count in BCD from 00 to 59. Passing 59 wraps the field to 00 and carries into the next field.
- R4: With hour bit 6 clear, the hour counts in BCD from 00 to 23. Passing 23 wraps to 00 and advances the date.
- R5: With hour bit 6 set, bits 4:0 hold a BCD hour from 1 to 12 and bit 5 is PM. 11 goes to 12 with PM toggled, 12 goes to 1 with PM unchanged, and the date advances only on 11 PM to 12 AM. Bit 6 is kept.
- R6: The weekday counts 1 to 7 and wraps to 1. The month counts 01 to 12 and wraps to 01 with a year carry. The year counts 00 to 99 and wraps to 00.
- R7: The day of month wraps to 01 after 30 for April, June, September and November, and after 31 for the other months except February. February ends at 29 when the BCD year is divisible by 4 and at 28 otherwise.
- R8: While control bit 7 is set, no field advances and no `sec_pulse` is produced. Writes are still accepted.
- R9: A write to any address from 0 to 6 restarts the prescaler, so the next advance comes TICKS_PER_SEC clock cycles after that write. A write also wins over an advance due in the same cycle.
- R10: `sec_pulse` is high for exactly one cycle per advance, in the first cycle that shows the advanced values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Selected register contents (combinational) |
| sec_pulse | output | 1 | One-cycle pulse after each one-second advance |

## Verification
The rollover assertions assume that software only writes legal BCD values: an hour that matches its own mode bit, a day within its month, and a weekday and month within range. The random stimulus builds every loaded time from these legal sets. It biases each field toward its last value so that chained carries happen often. Directed cases cover the 12-hour noon and midnight edges, leap and non-leap Februaries, and the century wrap.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int ADDR_W   = 3;
    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_WDAY = 3'd3;
    localparam logic [ADDR_W-1:0] A_MDAY = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd7;

    localparam int HALT_BIT = 7;
    localparam int H12_BIT  = 6;
    localparam int PM_BIT   = 5;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_t;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   wday: 8'h01, mday: 8'h01, mon: 8'h01,
                                   year: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic year_is_leap(input logic [7:0] y);
        logic [6:0] bin;
        bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return bin[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && !restart && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)      cnt <= '0;
        else if (run) cnt <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
    end

    // R9: a restart never produces a tick in the cycle that follows it
    a_r9_no_early_tick: assert property (@(posedge clk) disable iff (rst)
        (restart && TICKS_PER_SEC > 1) |=> !tick);

endmodule

// File: rtl/cal_time_step.sv
module cal_time_step
    import cal_pkg::*;
(
    input  logic [7:0] sec_i,
    input  logic [7:0] min_i,
    input  logic [7:0] hour_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic       day_carry
);
    logic sec_wrap, min_wrap;
    logic [4:0] h12;

    always_comb begin
        sec_wrap  = (sec_i == 8'h59);
        min_wrap  = (min_i == 8'h59);
        sec_o     = sec_wrap ? 8'h00 : bcd_inc(sec_i);
        min_o     = sec_wrap ? (min_wrap ? 8'h00 : bcd_inc(min_i)) : min_i;
        hour_o    = hour_i;
        day_carry = 1'b0;
        h12       = hour_i[4:0];
        if (sec_wrap && min_wrap) begin
            if (hour_i[H12_BIT]) begin
                if (h12 == 5'h11) begin
                    hour_o[4:0]    = 5'h12;
                    hour_o[PM_BIT] = !hour_i[PM_BIT];
                    day_carry      = hour_i[PM_BIT];
                end else if (h12 == 5'h12) begin
                    hour_o[4:0] = 5'h01;
                end else begin
                    hour_o[4:0] = bcd_inc({3'b000, h12})[4:0];
                end
            end else if (hour_i == 8'h23) begin
                hour_o    = 8'h00;
                day_carry = 1'b1;
            end else begin
                hour_o = bcd_inc(hour_i);
            end
        end
    end

endmodule

// File: rtl/cal_date_step.sv
module cal_date_step
    import cal_pkg::*;
(
    input  logic       day_carry,
    input  logic [7:0] wday_i,
    input  logic [7:0] mday_i,
    input  logic [7:0] mon_i,
    input  logic [7:0] year_i,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o
);
    logic month_end, year_end;

    always_comb begin
        month_end = (mday_i == month_last_day(mon_i, year_is_leap(year_i)));
        year_end  = month_end && (mon_i == 8'h12);
        wday_o = wday_i;
        mday_o = mday_i;
        mon_o  = mon_i;
        year_o = year_i;
        if (day_carry) begin
            wday_o = (wday_i == 8'h07) ? 8'h01 : wday_i + 8'h01;
            mday_o = month_end ? 8'h01 : bcd_inc(mday_i);
            if (month_end) mon_o = (mon_i == 8'h12) ? 8'h01 : bcd_inc(mon_i);
            if (year_end)  year_o = (year_i == 8'h99) ? 8'h00 : bcd_inc(year_i);
        end
    end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 50_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              sec_pulse
);
    cal_t       cal_q, cal_nxt;
    logic [7:0] ctrl_q;
    logic       time_wr, tick, day_carry;

    assign time_wr = wr_en && (wr_addr != A_CTRL);

    cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_presc (
        .clk(clk), .rst(rst), .run(!ctrl_q[HALT_BIT]),
        .restart(time_wr), .tick(tick));

    cal_time_step i_time (
        .sec_i(cal_q.sec), .min_i(cal_q.min), .hour_i(cal_q.hour),
        .sec_o(cal_nxt.sec), .min_o(cal_nxt.min), .hour_o(cal_nxt.hour),
        .day_carry(day_carry));

    cal_date_step i_date (
        .day_carry(day_carry),
        .wday_i(cal_q.wday), .mday_i(cal_q.mday), .mon_i(cal_q.mon), .year_i(cal_q.year),
        .wday_o(cal_nxt.wday), .mday_o(cal_nxt.mday), .mon_o(cal_nxt.mon), .year_o(cal_nxt.year));

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q     <= CAL_RESET;
            ctrl_q    <= 8'h00;
            sec_pulse <= 1'b0;
        end else begin
            sec_pulse <= tick;
            if (tick) cal_q <= cal_nxt;
            if (wr_en) begin
                case (wr_addr)
                    A_SEC:   cal_q.sec  <= wr_data;
                    A_MIN:   cal_q.min  <= wr_data;
                    A_HOUR:  cal_q.hour <= wr_data;
                    A_WDAY:  cal_q.wday <= wr_data;
                    A_MDAY:  cal_q.mday <= wr_data;
                    A_MON:   cal_q.mon  <= wr_data;
                    A_YEAR:  cal_q.year <= wr_data;
                    default: ctrl_q     <= wr_data;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = cal_q.sec;
            A_MIN:   rd_data = cal_q.min;
            A_HOUR:  rd_data = cal_q.hour;
            A_WDAY:  rd_data = cal_q.wday;
            A_MDAY:  rd_data = cal_q.mday;
            A_MON:   rd_data = cal_q.mon;
            A_YEAR:  rd_data = cal_q.year;
            default: rd_data = ctrl_q;
        endcase
    end

    // R8: a halted clock holds its seconds unless written
    a_r8_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[HALT_BIT] && !wr_en) |=> $stable(cal_q.sec));
    // R8: no pulse while halted
    a_r8_no_pulse: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[HALT_BIT] |=> !sec_pulse);
    // R10: pulse lasts one cycle
    a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (sec_pulse && TICKS_PER_SEC > 1) |=> !sec_pulse);
    // R9: a time write suppresses the next pulse
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        time_wr |=> !sec_pulse);
    // R3: seconds wrap from 59 to 00 on an advance
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && cal_q.sec == 8'h59) |=> (cal_q.sec == 8'h00));
    // R5: an advance keeps the hour format bit
    a_r5_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en) |=> (cal_q.hour[H12_BIT] == $past(cal_q.hour[H12_BIT])));
    // R6: weekday wraps from 7 to 1
    a_r6_wday_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && day_carry && cal_q.wday == 8'h07) |=> (cal_q.wday == 8'h01));

endmodule

// File: tb/test_bcd_calendar_clock.sv
module test_bcd_calendar_clock;
    localparam int TPS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sec_pulse;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] m [0:6];

    always #10 clk = ~clk;

    bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) i_bcd_calendar_clock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sec_pulse(sec_pulse));

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        int s, mi, h, d;
        logic pm, dc;
        dc = 1'b0;
        s = b2i(m[0]); mi = b2i(m[1]);
        if (s == 59) begin
            s = 0;
            if (mi == 59) begin
                mi = 0;
                if (m[2][6]) begin
                    h = b2i({3'b000, m[2][4:0]}); pm = m[2][5];
                    if (h == 11) begin h = 12; pm = !pm; dc = !pm; end
                    else if (h == 12) h = 1;
                    else h = h + 1;
                    m[2] = {m[2][7:6], pm, 5'(i2b(h))};
                end else begin
                    h = b2i(m[2]);
                    if (h == 23) begin h = 0; dc = 1'b1; end else h = h + 1;
                    m[2] = i2b(h);
                end
            end else mi = mi + 1;
        end else s = s + 1;
        m[0] = i2b(s); m[1] = i2b(mi);
        if (dc) begin
            m[3] = (m[3] == 8'h07) ? 8'h01 : m[3] + 8'h01;
            d = b2i(m[4]);
            if (d == dim(b2i(m[5]), b2i(m[6]))) begin
                m[4] = 8'h01;
                if (m[5] == 8'h12) begin
                    m[5] = 8'h01;
                    m[6] = (m[6] == 8'h99) ? 8'h00 : i2b(b2i(m[6]) + 1);
                end else m[5] = i2b(b2i(m[5]) + 1);
            end else m[4] = i2b(d + 1);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [7:0] s, mi, h, wd, md, mo, yr);
        m[0] = s; m[1] = mi; m[2] = h; m[3] = wd; m[4] = md; m[5] = mo; m[6] = yr;
        for (int a = 0; a < 7; a++) wr(a, m[a]);
    endtask

    task automatic check_regs(input string req);
        logic [7:0] v;
        compared++;
        for (int a = 0; a < 7; a++) begin
            rd_addr = 3'(a); #1; v = rd_data;
            if (v !== m[a]) begin
                mismatched++;
                $display("FAIL %s addr %0d actual %h expected %h", req, a, v, m[a]);
                break;
            end
        end
    endtask

    task automatic check_val(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // waits for the pulse, returns cycles counted from the last write
    task automatic wait_pulse(output int n);
        n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (sec_pulse || n > 100) break;
        end
    endtask

    task automatic step_check(input string req);
        int n;
        wait_pulse(n);
        model_tick();
        check_regs(req);
    endtask

    task automatic directed(input string req, input logic [7:0] s, mi, h, wd, md, mo, yr);
        int n;
        load(s, mi, h, wd, md, mo, yr);
        wait_pulse(n);
        check_val({req, " R9 restart delay"}, 8'(n), 8'(TPS));
        model_tick();
        check_regs(req);
        @(negedge clk);
        check_val({req, " R10 pulse width"}, {7'd0, sec_pulse}, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        mismatched++; compared++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        int seed, n, mo, yr, hh;
        logic h12;
        seed = 32'h1f2e3d;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R2 reset values
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00;
        check_regs("R2");
        rd_addr = 3'd7; #1; check_val("R2 ctrl", rd_data, 8'h00);
        check_val("R2 pulse", {7'd0, sec_pulse}, 8'h00);

        // R1 write and read back
        load(8'h12, 8'h34, 8'h05, 8'h03, 8'h15, 8'h06, 8'h42);
        @(negedge clk); check_regs("R1");

        directed("R3", 8'h58, 8'h10, 8'h10, 8'h02, 8'h10, 8'h03, 8'h10);
        directed("R3 min carry", 8'h59, 8'h09, 8'h10, 8'h02, 8'h10, 8'h03, 8'h10);
        directed("R4", 8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h03, 8'h10);
        directed("R4 hour carry", 8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h10);
        directed("R5 11AM", 8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h03, 8'h10);
        directed("R5 12PM", 8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h03, 8'h10);
        directed("R5 11PM", 8'h59, 8'h59, 8'h71, 8'h05, 8'h10, 8'h03, 8'h10);
        directed("R6", 8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        directed("R7 leap 28", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
        directed("R7 leap 29", 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h00);
        directed("R7 plain 28", 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        directed("R7 april", 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);

        // R8 halt
        wr(7, 8'h80);
        wr(0, 8'h20); m[0] = 8'h20;
        compared++;
        n = 0;
        repeat (4 * TPS) begin @(negedge clk); if (sec_pulse) n++; end
        if (n != 0) begin mismatched++; $display("FAIL R8 pulses actual %0d expected 0", n); end
        check_regs("R8 frozen");
        wr(7, 8'h00);
        step_check("R8 resume");

        // random legal loads
        for (int it = 0; it < 60; it++) begin
            mo = 1 + int'($urandom % 12);
            yr = ($urandom % 3 == 0) ? 99 : int'($urandom % 100);
            h12 = $urandom % 2;
            if (h12) begin
                hh = ($urandom % 2) ? 11 + int'($urandom % 2) : 1 + int'($urandom % 12);
                m[2] = {1'b0, 1'b1, 1'($urandom % 2), 5'(i2b(hh))};
            end else m[2] = i2b(($urandom % 2) ? 23 : int'($urandom % 24));
            load(i2b(55 + int'($urandom % 5)), ($urandom % 2) ? 8'h59 : i2b(int'($urandom % 60)),
                 m[2], 8'(1 + $urandom % 7),
                 i2b(($urandom % 2) ? dim(mo, yr) : 1 + int'($urandom % dim(mo, yr))),
                 i2b(($urandom % 3 == 0) ? 12 : mo), i2b(yr));
            if (b2i(m[5]) == 12 && b2i(m[4]) > 31) m[4] = 8'h31;
            repeat (1 + $urandom % 5) step_check("R3 R4 R5 R6 R7 random");
        end

        rd_addr = 3'd0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule